// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a physical frame to evict when the memory manager needs room for an incoming page. It keeps one referenced flag per frame and a rotating hand. The translation logic raises a one-cycle reference pulse for a frame whenever that frame is accessed, and the pulse sets the frame's flag.

On a victim request, the hand sweeps forward one frame per clock. A frame whose flag is clear becomes the victim. A frame whose flag is set loses its flag and is passed over. A frame held by the lock mask is skipped untouched, and this is how buffers pinned for I/O are kept resident.

The chosen index is returned together with a one-cycle done strobe, and the hand is left one frame past the victim. When every frame is locked, the sweep stops after one revolution and reports that no victim exists, instead of spinning forever.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset `done_o` and `none_o` are 0 and `victim_o` is 0. The hand starts at frame 0 and every referenced flag is clear, so the first request after reset returns frame 0 after one examined frame.
- R2: A request is sampled only while idle. The sweep examines exactly one frame per clock from the next edge on. `done_o` is high for a single cycle, becoming visible right after the edge on which the last frame was examined. With k frames examined, `done_o` is seen k edges after the edge that sampled `req_i`.
- R3: An unlocked frame at the hand whose flag is clear is returned on `victim_o`, with `done_o`=1 and `none_o`=0.
- R4: An unlocked frame at the hand whose flag is set has its flag cleared, and the hand moves on to the next frame.
- R5: The sweep may take a full revolution. If every unlocked frame has its flag set, the victim is the first unlocked frame reached on the second pass, after N+1 examinations when no frame is locked.
- R6: A frame with its `lock_i` bit at 1 is never returned as a victim. It is skipped in one cycle, and its referenced flag is left unchanged.
- R7: After a victim is chosen, the hand points one frame past it, wrapping from N-1 to 0.
- R8: A pulse on `ref_i[k]` sets the flag of frame k on that edge. It takes priority over a sweep clear of frame k on the same edge, so the flag stays set.
- R9: If N consecutive examinations in one sweep find locked frames, the block ends the sweep with `done_o`=1 and `none_o`=1 (k = N), and the hand is back at its starting frame.
- R10: `req_i` asserted while a sweep is in progress is ignored and produces no extra `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | N_FRAMES | Per-frame reference pulses, bit k for frame k |
| lock_i | input | N_FRAMES | Per-frame lock mask, 1 exempts the frame from eviction |
| req_i | input | 1 | Victim request, sampled while idle |
| done_o | output | 1 | One-cycle strobe ending a sweep |
| none_o | output | 1 | High with `done_o` when every frame was locked |
| victim_o | output | $clog2(N_FRAMES) | Index of the chosen frame, held until the next choice |

## Verification
The hardest case to reach is a reference pulse landing on the exact edge at which the sweep clears that same frame. The hand position is not visible at the ports, so the bench tracks it from the sequence of returned victims. It then sets every flag, issues a request, and holds the pulse for the frame at the hand on the first examination edge. The result shows at the ports: the sweep goes all the way round, clears the surviving flag, and returns the frame after it, one frame later than without the pulse. Stale flags on locked frames are exposed in a similar way: a locked frame is unlocked later, and the bench shows that the hand still passes it over once before choosing.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/clock_ref_bits.sv
module clock_ref_bits #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_FRAMES-1:0] set_i,
  input  logic                clr_en_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic [N_FRAMES-1:0] ref_o
);
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else if (set_i[g]) begin
        bit_q <= 1'b1;  // reference beats sweep clear
      end else if (clr_en_i && clr_idx_i == IDX_W'(g)) begin
        bit_q <= 1'b0;
      end
    end
    assign ref_o[g] = bit_q;
  end
endmodule

// File: rtl/clock_hand.sv
module clock_hand #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

  logic [IDX_W-1:0] hand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hand_q <= '0;
    end else if (adv_i) begin
      hand_q <= (hand_q == LAST) ? '0 : hand_q + 1'b1;
    end
  end

  assign hand_o = hand_q;
endmodule

// File: rtl/clock_sweep_ctrl.sv
module clock_sweep_ctrl
  import clock_sel_pkg::*;
#(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES),
  localparam int CNT_W = $clog2(N_FRAMES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W-1:0] hand_i,
  input  logic             cand_ref_i,
  input  logic             cand_lock_i,
  output logic             adv_o,
  output logic             clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             none_o,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(N_FRAMES - 1);

  sweep_state_e     state_q;
  logic [CNT_W-1:0] lock_run_q;
  logic             done_q, none_q;
  logic [IDX_W-1:0] victim_q;
  logic             examine, pick, all_locked;

  always_comb begin
    examine    = (state_q == ST_SWEEP);
    pick       = examine && !cand_lock_i && !cand_ref_i;
    all_locked = examine && cand_lock_i && (lock_run_q == RUN_LAST);
    clr_o      = examine && !cand_lock_i && cand_ref_i;
    adv_o      = examine;  // hand moves past every examined frame
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lock_run_q <= '0;
      done_q     <= 1'b0;
      none_q     <= 1'b0;
      victim_q   <= '0;
    end else begin
      done_q <= pick || all_locked;
      none_q <= all_locked;
      if (pick) victim_q <= hand_i;
      unique case (state_q)
        ST_IDLE: begin
          lock_run_q <= '0;
          if (req_i) state_q <= ST_SWEEP;
        end
        ST_SWEEP: begin
          lock_run_q <= cand_lock_i ? lock_run_q + 1'b1 : '0;
          if (pick || all_locked) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = examine;
  assign done_o   = done_q;
  assign none_o   = none_q;
  assign victim_o = victim_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_FRAMES-1:0] ref_i,
  input  logic [N_FRAMES-1:0] lock_i,
  input  logic                req_i,
  output logic                done_o,
  output logic                none_o,
  output logic [IDX_W-1:0]    victim_o
);
  logic [IDX_W-1:0]    hand_q;
  logic [N_FRAMES-1:0] ref_q;
  logic                adv, clr, busy;

  clock_hand #(.N_FRAMES(N_FRAMES)) u_hand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .hand_o (hand_q)
  );

  clock_ref_bits #(.N_FRAMES(N_FRAMES)) u_refs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ref_i),
    .clr_en_i  (clr),
    .clr_idx_i (hand_q),
    .ref_o     (ref_q)
  );

  clock_sweep_ctrl #(.N_FRAMES(N_FRAMES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .hand_i      (hand_q),
    .cand_ref_i  (ref_q[hand_q]),
    .cand_lock_i (lock_i[hand_q]),
    .adv_o       (adv),
    .clr_o       (clr),
    .busy_o      (busy),
    .done_o      (done_o),
    .none_o      (none_o),
    .victim_o    (victim_o)
  );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_FRAMES-1:0] ref_i,
  input logic [N_FRAMES-1:0] lock_i,
  input logic                done_o,
  input logic                none_o,
  input logic [IDX_W-1:0]    victim_o,
  input logic [IDX_W-1:0]    hand_q,
  input logic [N_FRAMES-1:0] ref_q,
  input logic                busy
);
  logic [N_FRAMES-1:0] prev_ref, prev_lock;
  logic [IDX_W-1:0]    prev_hand;
  logic                prev_clr;
  logic [IDX_W-1:0]    after_victim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ref  <= '0;
      prev_lock <= '0;
      prev_hand <= '0;
      prev_clr  <= 1'b0;
    end else begin
      prev_ref  <= ref_q;
      prev_lock <= lock_i;
      prev_hand <= hand_q;
      prev_clr  <= busy && !lock_i[hand_q] && ref_q[hand_q] && !ref_i[hand_q];
    end
  end

  assign after_victim = (victim_o == IDX_W'(N_FRAMES - 1)) ? '0 : victim_o + 1'b1;

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_none_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_o |-> done_o);
  // R3, R6
  a_r3_victim_clear_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !none_o) |-> (!prev_ref[victim_o] && !prev_lock[victim_o]));
  a_r4_swept_bit_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_clr |-> !ref_q[prev_hand]);
  a_r7_hand_past_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !none_o) |-> (hand_q == after_victim));

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_ref
    a_r8_ref_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_i[g] |=> ref_q[g]);
  end
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N_FRAMES(N_FRAMES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_i    (ref_i),
  .lock_i   (lock_i),
  .done_o   (done_o),
  .none_o   (none_o),
  .victim_o (victim_o),
  .hand_q   (hand_q),
  .ref_q    (ref_q),
  .busy     (busy)
);

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  ref_i = '0;
  logic [N-1:0]  lock_i = '0;
  logic          req_i = 1'b0;
  logic          done_o, none_o;
  logic [IW-1:0] victim_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // bench model state
  bit [N-1:0] m_ref = '0;
  int         m_hand = 0;

  clock_victim_sel #(.N_FRAMES(N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .lock_i(lock_i),
    .req_i(req_i), .done_o(done_o), .none_o(none_o), .victim_o(victim_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sweep per the requirements; updates model state
  task automatic model_sweep(output int v, output int exams, output bit none);
    int run = 0;
    exams = 0; none = 0; v = -1;
    while (v < 0 && !none) begin
      exams++;
      if (lock_i[m_hand]) begin
        run++;
        if (run == N) none = 1;
      end else begin
        run = 0;
        if (m_ref[m_hand]) m_ref[m_hand] = 0;
        else v = m_hand;
      end
      m_hand = (m_hand + 1) % N;
    end
  endtask

  task automatic pulse_refs(bit [N-1:0] mask);
    @(negedge clk_i); ref_i = mask;
    @(negedge clk_i); ref_i = '0;
    m_ref |= mask;
  endtask

  // waits for done after the request edge; returns edges counted
  task automatic wait_done(input int start, output int k);
    k = start;
    while (!done_o && k < 4 * N + 8) begin
      @(posedge clk_i); k++;
      @(negedge clk_i);
    end
  endtask

  task automatic do_req(string tag);
    int ev, en, k; bit enone;
    model_sweep(ev, en, enone);
    @(negedge clk_i); req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); req_i = 1'b0;
    wait_done(0, k);
    check({tag, " R2 latency"}, k, en);
    check({tag, " R9 none_o"}, int'(none_o), int'(enone));
    if (!enone) check({tag, " R3/R7 victim"}, int'(victim_o), ev);
    @(negedge clk_i);
    check({tag, " R2 done one cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset();
    check("R1 done_o", int'(done_o), 0);
    check("R1 none_o", int'(none_o), 0);
    check("R1 victim_o", int'(victim_o), 0);
    do_req("R1 first");
  endtask

  task automatic t_basic();
    do_req("R3 clear frame");
    do_req("R3 next frame");
  endtask

  task automatic t_clear();
    pulse_refs(8'b0000_1100);
    do_req("R4 skip set");
    pulse_refs(8'b1110_0011);
    do_req("R4 cleared earlier");
  endtask

  task automatic t_full_rev();
    pulse_refs('1);
    do_req("R5 full revolution");
  endtask

  task automatic t_lock();
    lock_i = 8'b0011_0000;
    pulse_refs(8'b0101_0000);
    do_req("R6 locked skip");
    lock_i = '0;
    for (int i = 0; i < 5; i++) do_req("R6 flag kept on locked frame");
  endtask

  task automatic t_all_locked();
    lock_i = '1;
    do_req("R9 all locked");
    lock_i = '0;
    do_req("R9 hand restored");
  endtask

  task automatic t_priority();
    int h, k;
    pulse_refs('1);
    h = m_hand;
    @(negedge clk_i); req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); req_i = 1'b0; ref_i = '0; ref_i[h] = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); ref_i = '0;
    wait_done(1, k);
    check("R8 latency", k, N + 2);
    check("R8 victim", int'(victim_o), (h + 1) % N);
    m_ref = '0;
    m_hand = (h + 2) % N;
  endtask

  task automatic t_busy_req();
    int ev, en, dones; bit enone;
    pulse_refs('1);
    model_sweep(ev, en, enone);
    @(negedge clk_i); req_i = 1'b1;
    @(negedge clk_i); req_i = 1'b0;
    dones = 0;
    for (int c = 0; c < 3 * N; c++) begin
      if (c == 3) req_i = 1'b1;
      if (c == 4) req_i = 1'b0;
      @(negedge clk_i);
      if (done_o) dones++;
    end
    check("R10 single done", dones, 1);
    check("R10 victim", int'(victim_o), ev);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_clear();
    t_full_rev();
    t_lock();
    t_all_locked();
    t_priority();
    t_busy_req();
    do_req("R7 after wrap");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule